// File: doc/BRIEF.md
# Jittered PWM Cycle Generator

This block produces the gate-drive pulse train of a fixed-frequency, peak-current-mode switching regulator. It uses a digital oscillator clocked by the system clock. Each oscillator period begins with the drive switched on. The drive is switched off when the digitised peak-current comparison asserts, or when a maximum on-time reached first forces it off. After switch-off the drive stays low until the next period. The comparison is not looked at during a blanking window right after turn-on, so the switching spike cannot end a pulse early.

The period is not constant. A slow triangular sweep moves it up and down by a fixed count every period, between nominal minus and nominal plus a parameterised depth. This spreads the switching energy over a band of frequencies. A skip request, sampled only at period boundaries, suppresses whole pulses for light-load burst operation. A soft-start ramp drives a current-limit code for the external comparator. The code climbs in equal steps from zero to full scale, and it starts again from zero each time the block is enabled. An off-time qualifier tells the overvoltage detector when the sense input may be trusted.

All times are counts of the system clock. The defaults give about 65 kHz at 250 MHz, a sweep of about ±6.4 % over about 5 ms, a blanking window of about 250 ns and a 2.5 ms soft-start.

Top module: `jitpwm_cycle_gen`

## Requirements
- R1: While `rst_n` is low, or while `run_en` is low, `drive_out`, `cycle_start` and `ovp_sample_en` are 0 and `ilim_code` is 0.
- R2: The first clock edge that samples `run_en` high starts a period. Each period raises `cycle_start` for exactly its first clock (phase 0), and `drive_out` is high from phase 0 unless that period is skipped.
- R3: If `cs_trip` is sampled high at phase t, with t >= BLANK_CYC, `drive_out` is low from phase t+1 onward. The pulse is then t+1 clocks wide.
- R4: A high `cs_trip` at phases 0 to BLANK_CYC-1 has no effect on the pulse.
- R5: Once a pulse has ended, `drive_out` stays low until the next period begins, even if `cs_trip` falls again.
- R6: The pulse is never wider than MAX_ON = floor(period * DUTY_Q8 / 256) clocks. If no trip ends it earlier, it is exactly MAX_ON clocks wide.
- R7: `skip_req` is sampled only at the clock edge that starts a period. When it is high, that whole period has no drive pulse. A change of `skip_req` inside a period leaves that period's pulse unchanged.
- R8: `ovp_sample_en` is never high together with `drive_out`. It is high from the second clock of the off time up to the end of the period, which gives period-W-1 clocks for a pulse of width W. In a skipped period it is high for the whole period.
- R9: The first period after enable is NOM_PERIOD clocks long. Each following period differs from the one before by exactly JIT_STEP. The sweep rises first and reverses on reaching NOM_PERIOD ± JIT_STEP*JIT_STEPS, so it repeats every 4*JIT_STEPS periods.
- R10: After n rising clock edges with `run_en` high, `ilim_code` equals min(floor(n/SS_TICK), SS_STEPS) * STEP, where STEP = floor((2^LIM_W - 1)/SS_STEPS).
- R11: Taking `run_en` low clears the soft-start code and the sweep. The next enable restarts both from their initial values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Run request; each rising transition is a (re)start |
| cs_trip | input | 1 | Digitised peak-current comparison, high = limit reached |
| skip_req | input | 1 | Request to skip pulses, sampled at period boundaries |
| drive_out | output | 1 | Gate drive pulse |
| cycle_start | output | 1 | One-clock marker of phase 0 of each period |
| ovp_sample_en | output | 1 | Off-time window in which the overvoltage check is valid |
| ilim_code | output | LIM_W | Soft-start current-limit code for the external comparator |

## Verification
Three of the pulse-ending rules can act on the same clock, and the bench sets up each overlap on purpose. A current trip can arrive at the exact phase where the duty limit also ends the pulse. A trip can arrive on the first unblanked phase. A trip pulse can lie wholly inside the blanking window. In each case only the pulse width counted between two `cycle_start` markers is judged, against the width the requirements predict. A skip request that changes inside a running pulse is also placed next to the boundary where it is sampled. All of this runs while the sweep is reversing, so period length, pulse width and off-time window are compared together for every period.

// File: rtl/jitpwm_pkg.sv
// Shared types for the jittered PWM cycle generator.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package jitpwm_pkg;

    // State of the drive pulse inside one oscillator period.
    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,   // block disabled
        GS_ON   = 2'd1,   // drive pulse active
        GS_OFF  = 2'd2    // pulse ended or skipped, wait for next period
    } gate_state_t;

endpackage

// File: rtl/jitpwm_sweep.sv
// Triangular period sweep. Holds the length of the next oscillator period
// and moves it by STEP counts each time a period starts. It rises first and
// reverses at nominal +/- STEP*STEPS.
// Assumes NOM_PERIOD > JIT_STEP*JIT_STEPS and that the result fits PW bits.
module jitpwm_sweep #(
    parameter int PW         = 12,
    parameter int NOM_PERIOD = 3846,
    parameter int JIT_STEP   = 3,
    parameter int JIT_STEPS  = 82
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          adv_i,
    output logic [PW-1:0] period_o
);
    localparam int DEPTH = JIT_STEP * JIT_STEPS;
    localparam logic [PW-1:0] P_NOM  = PW'(NOM_PERIOD);
    localparam logic [PW-1:0] P_HI   = PW'(NOM_PERIOD + DEPTH);
    localparam logic [PW-1:0] P_LO   = PW'(NOM_PERIOD - DEPTH);
    localparam logic [PW-1:0] P_STEP = PW'(JIT_STEP);

    logic [PW-1:0] per_q;
    logic          up_q;

    // Step the period once per oscillator period; reverse at the extremes.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            per_q <= P_NOM;
            up_q  <= 1'b1;
        end else if (adv_i) begin
            if (up_q) begin
                if (per_q == P_HI) begin
                    up_q  <= 1'b0;
                    per_q <= per_q - P_STEP;
                end else begin
                    per_q <= per_q + P_STEP;
                end
            end else begin
                if (per_q == P_LO) begin
                    up_q  <= 1'b1;
                    per_q <= per_q + P_STEP;
                end else begin
                    per_q <= per_q - P_STEP;
                end
            end
        end
    end

    assign period_o = per_q;

    // R9: the swept period stays inside the band
    a_r9_sweep_band: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (per_q >= P_LO && per_q <= P_HI));

    // R9: each advance moves the period by exactly one step
    a_r9_sweep_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(adv_i) && $past(run_i) && run_i) |->
        (per_q == $past(per_q) + P_STEP || per_q == $past(per_q) - P_STEP));

endmodule

// File: rtl/jitpwm_osc.sv
// Digital oscillator. Counts the phase of the current period. At every
// period boundary it latches the period length from the sweep and derives
// the maximum on-time from it.
// Assumes 0 < DUTY_Q8 < 256 and periods long enough for a non-zero on-time.
module jitpwm_osc #(
    parameter int PW      = 12,
    parameter int DUTY_Q8 = 230
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [PW-1:0] period_i,
    output logic [PW-1:0] phase_o,
    output logic [PW-1:0] max_on_o,
    output logic          wrap_o,
    output logic          start_o
);
    localparam int MW = PW + 8;

    logic          run_q;
    logic [PW-1:0] phase_q;
    logic [PW-1:0] per_q;
    logic [PW-1:0] max_on_q;
    logic [MW-1:0] prod;

    // A period begins on the first enabled edge or after the last phase.
    assign wrap_o = en_i && (!run_q || (phase_q == per_q - PW'(1)));

    // Maximum on-time as a fixed fraction of the incoming period.
    assign prod = MW'(period_i) * MW'(DUTY_Q8);

    // Phase counter with period and on-time limit latched per period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            run_q    <= 1'b0;
            phase_q  <= '0;
            per_q    <= '0;
            max_on_q <= '0;
        end else if (wrap_o) begin
            run_q    <= 1'b1;
            phase_q  <= '0;
            per_q    <= period_i;
            max_on_q <= prod[MW-1:8];
        end else begin
            phase_q  <= phase_q + PW'(1);
        end
    end

    assign phase_o  = phase_q;
    assign max_on_o = max_on_q;
    assign start_o  = run_q && (phase_q == '0);

    // R6: the on-time limit is non-zero and ends before the period does
    a_r6_limit_inside_period: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (max_on_q != '0 && max_on_q < per_q));

    // R2: the phase never runs past the latched period
    a_r2_phase_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (phase_q < per_q));

endmodule

// File: rtl/jitpwm_softstart.sv
// Soft-start ramp for the current-limit code. It climbs by one equal step
// every SS_TICK enabled clocks, from zero to STEP*SS_STEPS, and clears
// whenever the block is disabled.
// Assumes SS_TICK >= 2 and SS_STEPS <= 2^LIM_W - 1.
module jitpwm_softstart #(
    parameter int LIM_W    = 8,
    parameter int SS_STEPS = 32,
    parameter int SS_TICK  = 19531
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    output logic [LIM_W-1:0] code_o
);
    localparam int TW = $clog2(SS_TICK);
    localparam int STEP_I = ((1 << LIM_W) - 1) / SS_STEPS;
    localparam logic [LIM_W-1:0] STEP_C = LIM_W'(STEP_I);
    localparam logic [LIM_W-1:0] CODE_MAX = LIM_W'(STEP_I * SS_STEPS);
    localparam logic [TW-1:0] TICK_LAST = TW'(SS_TICK - 1);

    logic [TW-1:0]    tick_q;
    logic [LIM_W-1:0] code_q;

    // Count step intervals and raise the code until it saturates.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            tick_q <= '0;
            code_q <= '0;
        end else if (tick_q == TICK_LAST) begin
            tick_q <= '0;
            if (code_q != CODE_MAX) begin
                code_q <= code_q + STEP_C;
            end
        end else begin
            tick_q <= tick_q + TW'(1);
        end
    end

    assign code_o = code_q;

    // R10: the code only ever changes by one whole step upward
    a_r10_equal_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en_i) && code_q != $past(code_q)) |->
        (code_q == $past(code_q) + STEP_C));

    // R11: a disabled block restarts the ramp from zero
    a_r11_ramp_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en_i)) |-> (code_q == '0));

endmodule

// File: rtl/jitpwm_gate.sv
// Drive pulse control for one period. It turns on at the period boundary
// unless skip is requested there. It turns off on an unblanked current trip
// or at the on-time limit, and then stays off. It also produces the
// off-time qualifier for the overvoltage check.
// Assumes phase_i, max_on_i and wrap_i come from the oscillator.
module jitpwm_gate #(
    parameter int PW        = 12,
    parameter int BLANK_CYC = 63
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          wrap_i,
    input  logic [PW-1:0] phase_i,
    input  logic [PW-1:0] max_on_i,
    input  logic          trip_i,
    input  logic          skip_i,
    output logic          drive_o,
    output logic          ovp_en_o
);
    import jitpwm_pkg::*;

    localparam logic [PW-1:0] BLANK_L = PW'(BLANK_CYC);

    gate_state_t st_q, st_d;
    logic        ovp_q;
    logic        end_pulse;

    // A pulse ends on a trip outside blanking or on the last allowed phase.
    assign end_pulse = (trip_i && (phase_i >= BLANK_L)) ||
                       ((phase_i + PW'(1)) >= max_on_i);

    // Next pulse state from boundary, skip and termination conditions.
    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d = GS_IDLE;
        end else if (wrap_i) begin
            st_d = skip_i ? GS_OFF : GS_ON;
        end else if (st_q == GS_ON && end_pulse) begin
            st_d = GS_OFF;
        end
    end

    // Register the pulse state and the one-clock-delayed off-time window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= GS_IDLE;
            ovp_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            ovp_q <= en_i && (st_d != GS_ON) && (st_q != GS_ON);
        end
    end

    assign drive_o  = (st_q == GS_ON);
    assign ovp_en_o = ovp_q;

    // R4: a pulse never ends inside the blanking window except at the limit
    a_r4_blank_honoured: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(drive_o) && $past(rst_n) && $past(en_i)) |->
        (($past(phase_i) >= BLANK_L) || (($past(phase_i) + PW'(1)) >= $past(max_on_i))));

    // R5: the drive can only come back on at the start of a period
    a_r5_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_o) |-> (phase_i == '0));

    // R6: the drive is never on at or beyond the on-time limit
    a_r6_max_on: assert property (@(posedge clk) disable iff (!rst_n)
        drive_o |-> (phase_i < max_on_i));

    // R8: overvoltage sampling and drive are mutually exclusive
    a_r8_ovp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_en_o |-> !drive_o);

    // R8: the first off clock after a pulse is not yet a sampling clock
    a_r8_ovp_settle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_o) |-> !ovp_en_o);

endmodule

// File: rtl/jitpwm_cycle_gen.sv
// Jittered fixed-frequency peak-current PWM cycle generator. It ties
// together the period sweep, the oscillator, the pulse gate and the
// soft-start ramp. Comparators and slope compensation are outside.
// Assumes run_en, cs_trip and skip_req are synchronous to clk.
module jitpwm_cycle_gen #(
    parameter int NOM_PERIOD = 3846,
    parameter int JIT_STEP   = 3,
    parameter int JIT_STEPS  = 82,
    parameter int BLANK_CYC  = 63,
    parameter int DUTY_Q8    = 230,
    parameter int LIM_W      = 8,
    parameter int SS_STEPS   = 32,
    parameter int SS_TICK    = 19531
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             cs_trip,
    input  logic             skip_req,
    output logic             drive_out,
    output logic             cycle_start,
    output logic             ovp_sample_en,
    output logic [LIM_W-1:0] ilim_code
);
    localparam int DEPTH = JIT_STEP * JIT_STEPS;
    localparam int PW    = $clog2(NOM_PERIOD + DEPTH + 1);

    logic [PW-1:0] next_period;
    logic [PW-1:0] phase;
    logic [PW-1:0] max_on;
    logic          wrap;

    jitpwm_sweep #(
        .PW         (PW),
        .NOM_PERIOD (NOM_PERIOD),
        .JIT_STEP   (JIT_STEP),
        .JIT_STEPS  (JIT_STEPS)
    ) u_sweep (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_en),
        .adv_i    (wrap),
        .period_o (next_period)
    );

    jitpwm_osc #(
        .PW      (PW),
        .DUTY_Q8 (DUTY_Q8)
    ) u_osc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (run_en),
        .period_i (next_period),
        .phase_o  (phase),
        .max_on_o (max_on),
        .wrap_o   (wrap),
        .start_o  (cycle_start)
    );

    jitpwm_gate #(
        .PW        (PW),
        .BLANK_CYC (BLANK_CYC)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (run_en),
        .wrap_i   (wrap),
        .phase_i  (phase),
        .max_on_i (max_on),
        .trip_i   (cs_trip),
        .skip_i   (skip_req),
        .drive_o  (drive_out),
        .ovp_en_o (ovp_sample_en)
    );

    jitpwm_softstart #(
        .LIM_W    (LIM_W),
        .SS_STEPS (SS_STEPS),
        .SS_TICK  (SS_TICK)
    ) u_softstart (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (run_en),
        .code_o (ilim_code)
    );

endmodule

// File: tb/test_jitpwm_cycle_gen.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver task queues per-period stimulus and expected
// period, width and off-time window; a monitor measures each finished
// period and compares.
module test_jitpwm_cycle_gen;
    localparam int NOM = 40;
    localparam int JS  = 2;
    localparam int JN  = 3;
    localparam int DEPTH = JS * JN;
    localparam int BL  = 4;
    localparam int DQ  = 192;
    localparam int LW  = 8;
    localparam int SSN = 4;
    localparam int SST = 50;
    localparam int STEP_C = ((1 << LW) - 1) / SSN;
    localparam int NEVER = 1 << 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic cs_trip = 1'b0;
    logic skip_req = 1'b0;
    logic drive_out, cycle_start, ovp_sample_en;
    logic [LW-1:0] ilim_code;

    always #2 clk = ~clk;

    jitpwm_cycle_gen #(
        .NOM_PERIOD (NOM), .JIT_STEP (JS), .JIT_STEPS (JN), .BLANK_CYC (BL),
        .DUTY_Q8 (DQ), .LIM_W (LW), .SS_STEPS (SSN), .SS_TICK (SST)
    ) i_jitpwm_cycle_gen (
        .clk (clk), .rst_n (rst_n), .run_en (run_en), .cs_trip (cs_trip),
        .skip_req (skip_req), .drive_out (drive_out), .cycle_start (cycle_start),
        .ovp_sample_en (ovp_sample_en), .ilim_code (ilim_code)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    int    exp_per[$];
    int    exp_wid[$];
    int    exp_ovp[$];
    string exp_rq[$];
    string exp_prq[$];
    int    st_skip[$];
    int    st_at[$];
    int    st_len[$];

    int m_per;
    bit m_up;

    task automatic check(string rq, string what, int act, int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
        end
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Expected sweep restarts at nominal, rising first (R9, R11).
    task automatic model_reset();
        m_per = NOM;
        m_up  = 1'b1;
    endtask

    // Driver: queue one period's stimulus and its expected measurements.
    task automatic push_cycle(int skip, int at, int len, string rq, string prq);
        int p, mo, t, w;
        p  = m_per;
        mo = (p * DQ) / 256;
        if (m_up) begin
            if (m_per == NOM + DEPTH) begin m_up = 1'b0; m_per -= JS; end
            else m_per += JS;
        end else begin
            if (m_per == NOM - DEPTH) begin m_up = 1'b1; m_per += JS; end
            else m_per -= JS;
        end
        t = -1;
        if (len == 0 || at + len - 1 >= BL) t = (at > BL) ? at : BL;
        if (skip != 0)                 w = 0;
        else if (t >= 0 && t + 1 < mo) w = t + 1;
        else                           w = mo;
        exp_per.push_back(p);
        exp_wid.push_back(w);
        exp_ovp.push_back((w == 0) ? p : p - w - 1);
        exp_rq.push_back(rq);
        exp_prq.push_back(prq);
        st_skip.push_back(skip);
        st_at.push_back(at);
        st_len.push_back(len);
    endtask

    // Stimulator: per-period current trip and next-boundary skip request.
    int cur_at = NEVER;
    int cur_len = 0;
    int ph = 0;
    always @(negedge clk) begin
        if (!run_en) begin
            cur_at = NEVER; cur_len = 0; ph = 0; cs_trip = 1'b0;
        end else begin
            if (cycle_start) begin
                if (st_at.size() > 0) begin
                    cur_at  = st_at.pop_front();
                    cur_len = st_len.pop_front();
                    void'(st_skip.pop_front());
                end else begin
                    cur_at = NEVER; cur_len = 0;
                end
                ph = 0;
                skip_req = (st_skip.size() > 0) ? (st_skip[0] != 0) : 1'b0;
            end else begin
                ph++;
            end
            cs_trip = (cur_len == 0) ? (ph >= cur_at)
                                     : (ph >= cur_at && ph < cur_at + cur_len);
        end
    end

    // Monitor: measure each completed period and compare with the queue.
    bit open = 1'b0;
    int c_per, c_hi, c_ov;
    always @(negedge clk) begin
        if (!run_en) begin
            open = 1'b0;
        end else if (cycle_start) begin
            if (open && exp_per.size() > 0) begin
                check(exp_prq.pop_front(), "period length", c_per, exp_per.pop_front());
                check(exp_rq.pop_front(), "pulse width", c_hi, exp_wid.pop_front());
                check("R8", "ovp window clocks", c_ov, exp_ovp.pop_front());
            end
            open  = 1'b1;
            c_per = 1;
            c_hi  = drive_out ? 1 : 0;
            c_ov  = ovp_sample_en ? 1 : 0;
        end else if (open) begin
            c_per++;
            if (drive_out) c_hi++;
            if (ovp_sample_en) c_ov++;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion earlier", cyc);
            finish_up();
        end
    end

    // Run the queued periods with a fresh enable, then disable.
    task automatic run_queue();
        skip_req = (st_skip.size() > 0) ? (st_skip[0] != 0) : 1'b0;
        @(negedge clk);
        run_en = 1'b1;
        while (exp_per.size() > 0) @(negedge clk);
        run_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        // R1: reset holds everything quiet, even with run requested
        run_en = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", "drive in reset", drive_out, 0);
        check("R1", "cycle_start in reset", cycle_start, 0);
        check("R1", "ovp in reset", ovp_sample_en, 0);
        check("R1", "ilim in reset", ilim_code, 0);
        run_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R1", "drive while disabled", drive_out, 0);
        check("R1", "ovp while disabled", ovp_sample_en, 0);

        // Pulse termination, blanking, skip and duty-limit corner cases
        model_reset();
        push_cycle(0, 10,   0, "R2 R3", "R9");
        push_cycle(0, 12,   1, "R5",    "R9");
        push_cycle(0, 2,    0, "R4",    "R9");
        push_cycle(0, 1,    2, "R4 R7", "R9");
        push_cycle(1, 8,    0, "R7",    "R9");
        push_cycle(0, NEVER,0, "R6",    "R9");
        push_cycle(0, 4,    0, "R3",    "R9");
        push_cycle(0, 3,    1, "R4",    "R9");
        push_cycle(1, NEVER,0, "R7",    "R9");
        push_cycle(1, 5,    0, "R7",    "R9");
        push_cycle(0, 26,   0, "R6",    "R9");
        push_cycle(0, 30,   0, "R6",    "R9");
        push_cycle(0, 0,    0, "R4",    "R9");
        push_cycle(0, 20,   3, "R5",    "R9");
        run_queue();

        // R11: a second enable restarts the sweep from nominal
        model_reset();
        push_cycle(0, NEVER, 0, "R6", "R11");
        push_cycle(0, 15,    0, "R3", "R11");
        push_cycle(0, NEVER, 0, "R6", "R11");
        run_queue();

        // R10: soft-start code after n enabled edges
        @(negedge clk);
        run_en = 1'b1;
        repeat (SST - 1) @(negedge clk);
        check("R10", "ilim before first step", ilim_code, 0);
        @(negedge clk);
        check("R10", "ilim after first step", ilim_code, STEP_C);
        repeat (2 * SST + 5 - SST) @(negedge clk);
        check("R10", "ilim mid ramp", ilim_code, 2 * STEP_C);
        repeat (400 - (2 * SST + 5)) @(negedge clk);
        check("R10", "ilim saturated", ilim_code, SSN * STEP_C);

        // R11: disable clears the code, re-enable ramps from zero again
        run_en = 1'b0;
        @(negedge clk);
        check("R11", "ilim after disable", ilim_code, 0);
        check("R1", "drive after disable", drive_out, 0);
        run_en = 1'b1;
        repeat (SST - 1) @(negedge clk);
        check("R11", "ilim restart before step", ilim_code, 0);
        @(negedge clk);
        check("R11", "ilim restart first step", ilim_code, STEP_C);
        run_en = 1'b0;
        repeat (3) @(negedge clk);

        finish_up();
    end

endmodule